// File: doc/BRIEF.md
# Synchronous Keyboard Scan-Code Receiver

This block takes scan codes from an XT-style keyboard over a one-way synchronous serial link. The keyboard drives the data wire and pulses a shared clock wire. The clock wire is open-drain with a pull-up, so either side can pull it low. On each falling edge of that clock the receiver samples one bit. A frame is one start bit followed by eight data bits. Once a frame is complete, the byte goes into a single-entry holding register.

While the holding register is occupied, the block asserts an active-low interrupt and pulls the shared clock low. This stops the keyboard from sending more. Two level control inputs come from the host's control logic. The first is a clock-permit bit: while it is 0, the clock wire is also held low. The second is a buffer-permit bit: while it is 0, the holding register is emptied, and any frame that completes in that time is thrown away. The host reads the byte as a plain level. Reading has no side effect.

Top module: `kbd_rx`

## Requirements
- R1: A frame is nine falling edges of the synchronised keyboard clock. The first edge samples the start bit and the next eight edges sample data. The holding register fills only on the ninth edge.
- R2: Data bits arrive LSB first. The stored byte is made of the eight bits that follow the start bit. The value of the start bit is not checked.
- R3: While the holding register is occupied, `irq_n` is 0. Otherwise it is 1.
- R4: `kb_clk_hold` is 1 (clock pulled low) whenever the register is occupied or `clk_enable` is 0. In all other cases it is 0.
- R5: While `buf_enable` is 0, the register is emptied: `rx_byte` reads 0x00 and `irq_n` is 1, starting from the clock edge after `buf_enable` is seen low.
- R6: A frame that completes while `buf_enable` is 0 is discarded. It does not appear after `buf_enable` returns to 1.
- R7: An occupied register keeps its byte until it is cleared through `buf_enable`. There is no read-to-clear. Clock pulses the keyboard attempts while the line is held produce no edges and do not change the byte.
- R8: If no falling edge arrives for `TIMEOUT_CYCLES` system clocks in the middle of a frame, the bit count returns to idle. The next edge is then taken as a start bit.
- R9: After reset, `irq_n` is 1 and `rx_byte` is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| kb_clk_in | input | 1 | Sensed level of the shared keyboard clock wire |
| kb_data_in | input | 1 | Keyboard data wire |
| clk_enable | input | 1 | 1 lets the keyboard clock run; 0 holds it low |
| buf_enable | input | 1 | 1 allows loading; 0 empties the register and discards frames |
| kb_clk_hold | output | 1 | 1 pulls the shared clock wire low |
| irq_n | output | 1 | Active-low interrupt: register occupied |
| rx_byte | output | 8 | Holding register contents |

## Verification
Every one of the 256 byte values is sent as a full frame and then cleared. This sweep separates correct bit order and alignment from shifted or reversed capture, and it exercises each data-bit position at both levels. Separate frames cover the other cases: a frame sent while loading is disabled shows that discarding works; a burst attempted against an occupied register shows the flow-control hold at work; and an abandoned partial frame followed by a clean frame shows whether the idle timeout realigns the bit counter.

// File: rtl/kbd_rx.sv
module kbd_rx #(
  parameter int DATA_BITS      = 8,
  parameter int TIMEOUT_CYCLES = 4096
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 kb_clk_in,
  input  logic                 kb_data_in,
  input  logic                 clk_enable,
  input  logic                 buf_enable,
  output logic                 kb_clk_hold,
  output logic                 irq_n,
  output logic [DATA_BITS-1:0] rx_byte
);
  localparam int CNT_W = $clog2(DATA_BITS + 1);
  localparam int TO_W  = $clog2(TIMEOUT_CYCLES + 1);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_BITS);
  localparam logic [TO_W-1:0]  TO_LAST  = TO_W'(TIMEOUT_CYCLES - 1);

  logic [2:0]           clk_sync;
  logic [1:0]           dat_sync;
  logic [CNT_W-1:0]     bit_cnt;
  logic [TO_W-1:0]      idle_cnt;
  logic [DATA_BITS-1:0] shreg;
  logic [DATA_BITS-1:0] hold_reg;
  logic                 full;

  wire                 fall      = clk_sync[2] & ~clk_sync[1];
  wire                 last_fall = fall && (bit_cnt == LAST_BIT);
  wire [DATA_BITS-1:0] next_sh   = {dat_sync[1], shreg[DATA_BITS-1:1]};

  assign kb_clk_hold = full | ~clk_enable;
  assign irq_n       = ~full;
  assign rx_byte     = hold_reg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_sync <= 3'b111;
      dat_sync <= 2'b11;
    end else begin
      clk_sync <= {clk_sync[1:0], kb_clk_in};
      dat_sync <= {dat_sync[0], kb_data_in};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt  <= '0;
      idle_cnt <= '0;
      shreg    <= '0;
    end else begin
      if (fall || bit_cnt == '0) idle_cnt <= '0;
      else                       idle_cnt <= idle_cnt + 1'b1;

      if (fall) begin
        if (bit_cnt == '0) begin
          bit_cnt <= CNT_W'(1);
        end else begin
          shreg <= next_sh;
          if (bit_cnt == LAST_BIT) bit_cnt <= '0;
          else                     bit_cnt <= bit_cnt + 1'b1;
        end
      end else if (bit_cnt != '0 && idle_cnt == TO_LAST) begin
        bit_cnt <= '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full     <= 1'b0;
      hold_reg <= '0;
    end else if (!buf_enable) begin
      full     <= 1'b0;
      hold_reg <= '0;
    end else if (last_fall && !full) begin
      full     <= 1'b1;
      hold_reg <= next_sh;
    end
  end

  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    bit_cnt <= LAST_BIT); // R1
  AST_FILL_ON_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_n) |-> $past(last_fall)); // R1
  AST_HOLD_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_n |-> kb_clk_hold); // R4
  AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    !buf_enable |=> (irq_n && rx_byte == '0)); // R5
  AST_KEEP_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_n && buf_enable) |=> $stable(rx_byte)); // R7
endmodule

// File: tb/kbd_rx_bench.sv
module kbd_rx_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic kb_drv = 1'b1;
  logic kb_data = 1'b1;
  logic clk_enable = 1'b1;
  logic buf_enable = 1'b1;
  logic kb_clk_hold, irq_n;
  logic [7:0] rx_byte;
  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  wire kb_line = kb_drv & ~kb_clk_hold;

  always #10 clk = ~clk;

  kbd_rx #(.DATA_BITS(8), .TIMEOUT_CYCLES(64)) u_kbd_rx (
    .clk(clk), .rst_n(rst_n), .kb_clk_in(kb_line), .kb_data_in(kb_data),
    .clk_enable(clk_enable), .buf_enable(buf_enable),
    .kb_clk_hold(kb_clk_hold), .irq_n(irq_n), .rx_byte(rx_byte));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(input bit b);
    kb_data = b;
    cyc(8);
    kb_drv = 1'b0;
    cyc(8);
    kb_drv = 1'b1;
  endtask

  task automatic send_frame(input logic [7:0] v);
    send_bit(1'b1);
    for (int i = 0; i < 8; i++) send_bit(v[i]);
    cyc(8);
  endtask

  task automatic flush();
    buf_enable = 1'b0;
    cyc(2);
    buf_enable = 1'b1;
    cyc(2);
  endtask

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(2);
    chk(irq_n == 1'b1, "R9", irq_n, 1);
    chk(rx_byte == 8'h00, "R9", rx_byte, 0);
    chk(kb_clk_hold == 1'b0, "R4", kb_clk_hold, 0);

    for (int v = 0; v < 256; v++) begin
      send_frame(8'(v));
      chk(rx_byte == 8'(v), "R2", rx_byte, v);
      chk(irq_n == 1'b0, "R3", irq_n, 0);
      chk(kb_clk_hold == 1'b1, "R4", kb_clk_hold, 1);
      flush();
      chk(irq_n == 1'b1 && rx_byte == 8'h00, "R5", rx_byte, 0);
      chk(kb_clk_hold == 1'b0, "R4", kb_clk_hold, 0);
    end

    // R1: eight edges only leave the register empty
    send_bit(1'b1);
    for (int i = 0; i < 7; i++) send_bit(1'b0);
    cyc(8);
    chk(irq_n == 1'b1, "R1", irq_n, 1);
    send_bit(1'b1);
    cyc(8);
    chk(irq_n == 1'b0, "R1", irq_n, 0);
    chk(rx_byte == 8'h80, "R1", rx_byte, 8'h80);
    flush();

    // R6: frame completing with loading disabled is dropped
    buf_enable = 1'b0;
    send_frame(8'h3C);
    chk(irq_n == 1'b1 && rx_byte == 8'h00, "R6", rx_byte, 0);
    buf_enable = 1'b1;
    cyc(4);
    chk(irq_n == 1'b1 && rx_byte == 8'h00, "R6", rx_byte, 0);

    // R7: occupied register blocks further clocks and keeps its byte
    send_frame(8'h11);
    send_frame(8'h22);
    cyc(20);
    chk(rx_byte == 8'h11, "R7", rx_byte, 8'h11);
    chk(irq_n == 1'b0, "R7", irq_n, 0);
    flush();

    // R4: clock permit low holds the line with an empty register
    clk_enable = 1'b0;
    cyc(2);
    chk(kb_clk_hold == 1'b1, "R4", kb_clk_hold, 1);
    chk(irq_n == 1'b1, "R3", irq_n, 1);
    clk_enable = 1'b1;
    cyc(2);
    chk(kb_clk_hold == 1'b0, "R4", kb_clk_hold, 0);

    // R8: abandoned partial frame is forgotten after the idle timeout
    send_bit(1'b1);
    send_bit(1'b0);
    send_bit(1'b1);
    send_bit(1'b1);
    cyc(200);
    chk(irq_n == 1'b1, "R8", irq_n, 1);
    send_frame(8'hA5);
    chk(rx_byte == 8'hA5, "R8", rx_byte, 8'hA5);
    chk(irq_n == 1'b0, "R8", irq_n, 0);
    flush();

    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule